// File: doc/BRIEF.md
# Express-Mode Socket Control Registers and Data-Line Steering

This block extends an SD host controller's register space with a few control bits and holds the select logic for a socket whose four data lines are shared between an SD card interface and a PCIe link. Software sets a supply bit that turns on the second card rail (1.8 V) and, with the same bit, moves the socket data lines from the SD host over to the PCIe reference clock and sideband pins. A separate interface-enable bit drives an active-low presence line into the PCIe hot-plug port. This lets the SD software decide when the PCIe driver sees a card arrive or leave. A read-only capability word tells the SD software whether the controller supports the express mode at all.

The register port is byte-addressed, 32 bits wide, with byte enables and a read result that is registered. The socket side carries digital output, output-enable and input vectors for the four data lines. The analog switch and the differential clock buffers sit outside the block. A card-detect input passes through a synchronizer. When the card is gone, both control bits are forced clear.

Top module: `sdx_mode_ctrl`

## Requirements
- R1: After reset, the supply bit and the interface-enable bit are 0. vdd2_en_o and pcie_sel_o are 0, prsnt_n_o is 1, and both control words read back as 0.
- R2: The supply bit is bit 4 of byte 0x29. On the 32-bit port this is bit 12 of the word at 0x28, in byte lane 1. Writing it to 1 sets vdd2_en_o and pcie_sel_o on the next clock edge. Writing it to 0 clears both.
- R3: The interface-enable bit is bit 0 of byte 0x55. On the 32-bit port this is bit 8 of the word at 0x54, in byte lane 1. When it is 1, prsnt_n_o is 0. When it is 0, prsnt_n_o is 1.
- R4: A write changes a control bit only when the byte enable of that bit's lane is 1. A write to any address that is not word-aligned changes nothing.
- R5: Reserved bits of every word read as 0 and ignore writes, including every bit of the capability words.
- R6: With EXPRESS_CAP=1, bit 20 of the word at 0x40 reads 1 (express support). Bit 28 of the word at 0x44 also reads 1 (bit 60 of the 64-bit capability register, 1.8 V second-rail support).
- R7: With EXPRESS_CAP=0, both capability bits read 0, and writes to the supply bit and the interface-enable bit have no effect.
- R8: In SD mode (pcie_sel_o=0), each socket data line's output and output-enable follow the SD host's. The SD host receives the socket inputs unchanged, and clkreq_n_o is 1.
- R9: In PCIe mode, socket line 0 drives refclk_p_i, line 1 drives refclk_n_i and line 3 drives perst_n_i, each with output-enable 1. The SD host's data inputs all read 1.
- R10: In PCIe mode, socket line 2 is open drain. Its output value is 0, its output-enable equals clkreq_drive_i, and clkreq_n_o returns the socket line 2 input.
- R11: When card_in_i is 0 for SYNC_STAGES+1 cycles, both control bits are 0. While card_in_i stays 0, writes to them have no effect.
- R12: rd_data_o holds the addressed word on the clock edge after rd_en_i is sampled high, and keeps it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| card_in_i | input | 1 | Socket card-detect, 1 when a card is present (asynchronous) |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_be_i | input | 4 | Byte enables of the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| vdd2_en_o | output | 1 | Second-rail supply enable |
| pcie_sel_o | output | 1 | Front-end switch select, 1 for PCIe |
| prsnt_n_o | output | 1 | Active-low card presence to the PCIe hot-plug port |
| sdh_dout_i | input | 4 | SD host data outputs |
| sdh_doe_i | input | 4 | SD host data output-enables |
| sdh_din_o | output | 4 | Data inputs seen by the SD host |
| refclk_p_i | input | 1 | PCIe reference clock, positive leg (digital view) |
| refclk_n_i | input | 1 | PCIe reference clock, negative leg (digital view) |
| perst_n_i | input | 1 | PCIe reset from the root port, active low |
| clkreq_drive_i | input | 1 | PCIe host request to pull the clock-request line low |
| clkreq_n_o | output | 1 | Clock-request line level seen by the PCIe host |
| sock_dout_o | output | 4 | Socket data line output values |
| sock_doe_o | output | 4 | Socket data line output-enables |
| sock_din_i | input | 4 | Socket data line input levels |

## Verification
The bench builds two copies side by side on the same stimulus. One uses the defaults (ADDR_W=8, SYNC_STAGES=2, EXPRESS_CAP=1) and carries the mode switching, steering and card-removal tests. The other uses EXPRESS_CAP=0, so the bench can see that the capability reads as 0 and that control writes are dropped when the feature is absent. With a two-stage synchronizer, the removal clear arrives at a known cycle, and the bench checks both that the bits are clear and that writes are refused while the card is out.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned REG_B    = REG_W / 8;
  localparam int unsigned LANES    = 4;

  // word-aligned offsets of the control and capability words
  localparam int unsigned OFS_PWR  = 'h28;
  localparam int unsigned OFS_CAPL = 'h40;
  localparam int unsigned OFS_CAPH = 'h44;
  localparam int unsigned OFS_IFEN = 'h54;

  // bit positions inside the 32-bit words
  localparam int unsigned BIT_VDD2 = 12;  // byte 0x29 bit 4
  localparam int unsigned BIT_IFEN = 8;   // byte 0x55 bit 0
  localparam int unsigned BIT_XCAP = 20;  // express support
  localparam int unsigned BIT_V2CP = 28;  // capability bit 60

  // lane indices of the shared socket lines in PCIe mode
  localparam int unsigned LN_REFP  = 0;
  localparam int unsigned LN_REFN  = 1;
  localparam int unsigned LN_CREQ  = 2;
  localparam int unsigned LN_PRST  = 3;

  typedef enum logic {MODE_SD = 1'b0, MODE_PCIE = 1'b1} sdx_mode_e;
endpackage

// File: rtl/sdx_cd_sync.sv
module sdx_cd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= async_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdx_regs.sv
module sdx_regs
  import sdx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter bit          EXPRESS_CAP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              card_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_B-1:0]  wr_be_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              vdd2_o,
  output logic              ifen_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam logic [REG_W-1:0] PWR_MASK  = EXPRESS_CAP ? (REG_W'(1) << BIT_VDD2) : '0;
  localparam logic [REG_W-1:0] IFEN_MASK = EXPRESS_CAP ? (REG_W'(1) << BIT_IFEN) : '0;
  localparam logic [REG_W-1:0] CAPL_VAL  = EXPRESS_CAP ? (REG_W'(1) << BIT_XCAP) : '0;
  localparam logic [REG_W-1:0] CAPH_VAL  = EXPRESS_CAP ? (REG_W'(1) << BIT_V2CP) : '0;

  logic [REG_W-1:0] pwr_q, ifen_q, rd_word, bemask;
  logic aligned, hit_pwr, hit_ifen, hit_capl, hit_caph;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign hit_pwr  = aligned && (addr_i[ADDR_W-1:2] == WIDX_W'(OFS_PWR  >> 2));
  assign hit_ifen = aligned && (addr_i[ADDR_W-1:2] == WIDX_W'(OFS_IFEN >> 2));
  assign hit_capl = aligned && (addr_i[ADDR_W-1:2] == WIDX_W'(OFS_CAPL >> 2));
  assign hit_caph = aligned && (addr_i[ADDR_W-1:2] == WIDX_W'(OFS_CAPH >> 2));

  generate
    for (genvar b = 0; b < REG_B; b++) begin : g_be
      assign bemask[8*b +: 8] = {8{wr_be_i[b]}};
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pwr_q  <= '0;
      ifen_q <= '0;
    end else if (!card_ok_i) begin
      pwr_q  <= '0;
      ifen_q <= '0;
    end else if (wr_en_i) begin
      if (hit_pwr)
        pwr_q  <= ((pwr_q  & ~bemask) | (wr_data_i & bemask)) & PWR_MASK;
      if (hit_ifen)
        ifen_q <= ((ifen_q & ~bemask) | (wr_data_i & bemask)) & IFEN_MASK;
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit_pwr)  rd_word = pwr_q;
    if (hit_ifen) rd_word = ifen_q;
    if (hit_capl) rd_word = CAPL_VAL;
    if (hit_caph) rd_word = CAPH_VAL;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_word;
  end

  assign vdd2_o = pwr_q[BIT_VDD2];
  assign ifen_o = ifen_q[BIT_IFEN];
endmodule

// File: rtl/sdx_lane_mux.sv
module sdx_lane_mux
  import sdx_pkg::*;
(
  input  logic             mode_i,
  input  logic [LANES-1:0] sdh_dout_i,
  input  logic [LANES-1:0] sdh_doe_i,
  output logic [LANES-1:0] sdh_din_o,
  input  logic             refclk_p_i,
  input  logic             refclk_n_i,
  input  logic             perst_n_i,
  input  logic             clkreq_drive_i,
  output logic             clkreq_n_o,
  output logic [LANES-1:0] sock_dout_o,
  output logic [LANES-1:0] sock_doe_o,
  input  logic [LANES-1:0] sock_din_i
);
  logic [LANES-1:0] px_out, px_oe;

  always_comb begin
    px_out          = '0;
    px_oe           = '1;
    px_out[LN_REFP] = refclk_p_i;
    px_out[LN_REFN] = refclk_n_i;
    px_out[LN_PRST] = perst_n_i;
    px_out[LN_CREQ] = 1'b0;            // open drain: only ever pulls low
    px_oe[LN_CREQ]  = clkreq_drive_i;
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
        if (mode_i == MODE_PCIE) begin
          sock_dout_o[i] = px_out[i];
          sock_doe_o[i]  = px_oe[i];
          sdh_din_o[i]   = 1'b1;
        end else begin
          sock_dout_o[i] = sdh_dout_i[i];
          sock_doe_o[i]  = sdh_doe_i[i];
          sdh_din_o[i]   = sock_din_i[i];
        end
      end
    end
  endgenerate

  assign clkreq_n_o = (mode_i == MODE_PCIE) ? sock_din_i[LN_CREQ] : 1'b1;
endmodule

// File: rtl/sdx_mode_ctrl.sv
module sdx_mode_ctrl
  import sdx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          EXPRESS_CAP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              card_in_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_be_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o,
  output logic              vdd2_en_o,
  output logic              pcie_sel_o,
  output logic              prsnt_n_o,
  input  logic [3:0]        sdh_dout_i,
  input  logic [3:0]        sdh_doe_i,
  output logic [3:0]        sdh_din_o,
  input  logic              refclk_p_i,
  input  logic              refclk_n_i,
  input  logic              perst_n_i,
  input  logic              clkreq_drive_i,
  output logic              clkreq_n_o,
  output logic [3:0]        sock_dout_o,
  output logic [3:0]        sock_doe_o,
  input  logic [3:0]        sock_din_i
);
  logic card_ok, vdd2, ifen;

  sdx_cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(card_in_i), .sync_o(card_ok)
  );

  sdx_regs #(.ADDR_W(ADDR_W), .EXPRESS_CAP(EXPRESS_CAP)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .card_ok_i(card_ok),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_be_i(wr_be_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .vdd2_o(vdd2), .ifen_o(ifen)
  );

  assign vdd2_en_o  = vdd2;
  assign pcie_sel_o = vdd2;
  assign prsnt_n_o  = ~ifen;

  sdx_lane_mux u_mux (
    .mode_i(vdd2), .sdh_dout_i(sdh_dout_i), .sdh_doe_i(sdh_doe_i),
    .sdh_din_o(sdh_din_o), .refclk_p_i(refclk_p_i), .refclk_n_i(refclk_n_i),
    .perst_n_i(perst_n_i), .clkreq_drive_i(clkreq_drive_i),
    .clkreq_n_o(clkreq_n_o), .sock_dout_o(sock_dout_o),
    .sock_doe_o(sock_doe_o), .sock_din_i(sock_din_i)
  );
endmodule

// File: rtl/sdx_mode_ctrl_chk.sv
module sdx_mode_ctrl_chk #(
  parameter int unsigned ADDR_W      = 8,
  parameter bit          EXPRESS_CAP = 1'b1
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [3:0]        wr_be_i,
  input logic [31:0]       wr_data_i,
  input logic              vdd2_en_o,
  input logic              pcie_sel_o,
  input logic              prsnt_n_o,
  input logic [3:0]        sdh_dout_i,
  input logic [3:0]        sdh_doe_i,
  input logic [3:0]        sdh_din_o,
  input logic              clkreq_drive_i,
  input logic [3:0]        sock_dout_o,
  input logic [3:0]        sock_doe_o
);
  // R2
  vdd2_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(vdd2_en_o) |-> $past(wr_en_i && addr_i == ADDR_W'('h28) && wr_be_i[1] && wr_data_i[12]));

  // R3
  prsnt_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(prsnt_n_o) |-> $past(wr_en_i && addr_i == ADDR_W'('h54) && wr_be_i[1] && wr_data_i[8]));

  // R8
  sd_steer_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !pcie_sel_o |-> (sock_dout_o == sdh_dout_i && sock_doe_o == sdh_doe_i));

  // R9
  sd_isolated_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pcie_sel_o |-> sdh_din_o == 4'hF);

  // R10
  clkreq_od_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pcie_sel_o |-> (!sock_dout_o[2] && sock_doe_o[2] == clkreq_drive_i));

  // R7
  no_feature_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !EXPRESS_CAP |-> (!vdd2_en_o && prsnt_n_o));
endmodule

bind sdx_mode_ctrl sdx_mode_ctrl_chk #(.ADDR_W(ADDR_W), .EXPRESS_CAP(EXPRESS_CAP)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_be_i(wr_be_i), .wr_data_i(wr_data_i), .vdd2_en_o(vdd2_en_o),
  .pcie_sel_o(pcie_sel_o), .prsnt_n_o(prsnt_n_o), .sdh_dout_i(sdh_dout_i),
  .sdh_doe_i(sdh_doe_i), .sdh_din_o(sdh_din_o), .clkreq_drive_i(clkreq_drive_i),
  .sock_dout_o(sock_dout_o), .sock_doe_o(sock_doe_o)
);

// File: tb/tb_sdx_mode_ctrl.sv
module tb_sdx_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, card_in = 1;
  logic [7:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [3:0] sdh_dout = 0, sdh_doe = 0, sock_din = 0;
  logic refp = 0, refn = 0, perst_n = 0, creq_drv = 0;

  logic [31:0] rd_data, rd_data_off;
  logic vdd2, sel, prsnt_n, creq_n;
  logic [3:0] sdh_din, sock_dout, sock_doe;
  logic vdd2_off, sel_off, prsnt_n_off, creq_n_off;
  logic [3:0] sdh_din_off, sock_dout_off, sock_doe_off;

  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdx_mode_ctrl dut (
    .clk_i(clk), .rst_i(rst), .card_in_i(card_in), .addr_i(addr),
    .wr_en_i(wr_en), .wr_be_i(wr_be), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .vdd2_en_o(vdd2), .pcie_sel_o(sel), .prsnt_n_o(prsnt_n),
    .sdh_dout_i(sdh_dout), .sdh_doe_i(sdh_doe), .sdh_din_o(sdh_din),
    .refclk_p_i(refp), .refclk_n_i(refn), .perst_n_i(perst_n),
    .clkreq_drive_i(creq_drv), .clkreq_n_o(creq_n), .sock_dout_o(sock_dout),
    .sock_doe_o(sock_doe), .sock_din_i(sock_din)
  );

  sdx_mode_ctrl #(.EXPRESS_CAP(1'b0)) dut_off (
    .clk_i(clk), .rst_i(rst), .card_in_i(card_in), .addr_i(addr),
    .wr_en_i(wr_en), .wr_be_i(wr_be), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data_off), .vdd2_en_o(vdd2_off), .pcie_sel_o(sel_off),
    .prsnt_n_o(prsnt_n_off), .sdh_dout_i(sdh_dout), .sdh_doe_i(sdh_doe),
    .sdh_din_o(sdh_din_off), .refclk_p_i(refp), .refclk_n_i(refn),
    .perst_n_i(perst_n), .clkreq_drive_i(creq_drv), .clkreq_n_o(creq_n_off),
    .sock_dout_o(sock_dout_off), .sock_doe_o(sock_doe_off), .sock_din_i(sock_din)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    addr = a; wr_data = d; wr_be = be; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wr_be = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic t_reset;
    chk("R1 vdd2", vdd2, 0);
    chk("R1 sel", sel, 0);
    chk("R1 prsnt_n", prsnt_n, 1);
    rd(8'h28, rv); chk("R1 pwr word", rv, 0);
    rd(8'h54, rv); chk("R1 ifen word", rv, 0);
  endtask

  task automatic t_power;
    wr(8'h28, 32'h0000_1000, 4'b0010);
    chk("R2 vdd2 on", vdd2, 1);
    chk("R2 sel on", sel, 1);
    rd(8'h28, rv); chk("R12 pwr readback", rv, 32'h0000_1000);
    @(negedge clk); chk("R12 held", rd_data, 32'h0000_1000);
    wr(8'h28, 32'h0, 4'b0010);
    chk("R2 vdd2 off", vdd2, 0);
    chk("R2 sel off", sel, 0);
  endtask

  task automatic t_ifen;
    wr(8'h54, 32'h0000_0100, 4'b0010);
    chk("R3 prsnt low", prsnt_n, 0);
    rd(8'h54, rv); chk("R3 ifen readback", rv, 32'h0000_0100);
    wr(8'h54, 32'h0, 4'b1111);
    chk("R3 prsnt high", prsnt_n, 1);
  endtask

  task automatic t_byte_en;
    wr(8'h28, 32'hFFFF_FFFF, 4'b1101);
    chk("R4 lane1 off", vdd2, 0);
    wr(8'h55, 32'hFFFF_FFFF, 4'b1111);
    chk("R4 unaligned", prsnt_n, 1);
    wr(8'h29, 32'hFFFF_FFFF, 4'b1111);
    chk("R4 unaligned pwr", vdd2, 0);
  endtask

  task automatic t_reserved;
    wr(8'h28, 32'hFFFF_FFFF, 4'b1111);
    rd(8'h28, rv); chk("R5 pwr reserved", rv, 32'h0000_1000);
    wr(8'h54, 32'hFFFF_FFFF, 4'b1111);
    rd(8'h54, rv); chk("R5 ifen reserved", rv, 32'h0000_0100);
    wr(8'h40, 32'h0, 4'b1111);
    rd(8'h40, rv); chk("R6 cap low", rv, 32'h0010_0000);
    rd(8'h44, rv); chk("R6 cap high", rv, 32'h1000_0000);
    rd(8'h30, rv); chk("R5 unmapped", rv, 0);
    wr(8'h28, 32'h0, 4'b1111);
    wr(8'h54, 32'h0, 4'b1111);
  endtask

  task automatic t_nocap;
    wr(8'h28, 32'hFFFF_FFFF, 4'b1111);
    wr(8'h54, 32'hFFFF_FFFF, 4'b1111);
    chk("R7 vdd2 stays off", vdd2_off, 0);
    chk("R7 prsnt stays high", prsnt_n_off, 1);
    rd(8'h40, rv); chk("R7 cap low", rd_data_off, 0);
    rd(8'h44, rv); chk("R7 cap high", rd_data_off, 0);
    wr(8'h28, 32'h0, 4'b1111);
    wr(8'h54, 32'h0, 4'b1111);
  endtask

  task automatic t_sd_mux;
    sdh_dout = 4'b1010; sdh_doe = 4'b0110; sock_din = 4'b0011;
    #1;
    chk("R8 dout", sock_dout, 4'b1010);
    chk("R8 doe", sock_doe, 4'b0110);
    chk("R8 din", sdh_din, 4'b0011);
    chk("R8 clkreq idle", creq_n, 1);
    sdh_dout = 4'b0101; sdh_doe = 4'b1001; sock_din = 4'b1100;
    #1;
    chk("R8 dout b", sock_dout, 4'b0101);
    chk("R8 din b", sdh_din, 4'b1100);
  endtask

  task automatic t_pcie_mux;
    wr(8'h28, 32'h0000_1000, 4'b0010);
    refp = 1; refn = 0; perst_n = 1; creq_drv = 0; sock_din = 4'b0000;
    #1;
    chk("R9 dout", sock_dout, 4'b1001);
    chk("R9 doe", sock_doe, 4'b1011);
    chk("R9 sd din", sdh_din, 4'hF);
    refp = 0; refn = 1; perst_n = 0;
    #1;
    chk("R9 dout b", sock_dout, 4'b0010);
  endtask

  task automatic t_clkreq;
    creq_drv = 1; sock_din = 4'b0000;
    #1;
    chk("R10 drive low oe", sock_doe[2], 1);
    chk("R10 drive low val", sock_dout[2], 0);
    chk("R10 level low", creq_n, 0);
    creq_drv = 0; sock_din = 4'b0100;
    #1;
    chk("R10 release oe", sock_doe[2], 0);
    chk("R10 level high", creq_n, 1);
  endtask

  task automatic t_card_loss;
    wr(8'h54, 32'h0000_0100, 4'b0010);
    chk("R11 pre ifen", prsnt_n, 0);
    chk("R11 pre vdd2", vdd2, 1);
    @(negedge clk); card_in = 0;
    repeat (3) @(negedge clk);
    chk("R11 vdd2 cleared", vdd2, 0);
    chk("R11 prsnt released", prsnt_n, 1);
    wr(8'h28, 32'h0000_1000, 4'b0010);
    chk("R11 write refused", vdd2, 0);
    card_in = 1;
    repeat (4) @(negedge clk);
    wr(8'h28, 32'h0000_1000, 4'b0010);
    chk("R11 write after reinsert", vdd2, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    t_reset();
    t_power();
    t_ifen();
    t_byte_en();
    t_reserved();
    t_nocap();
    t_sd_mux();
    t_pcie_mux();
    t_clkreq();
    t_card_loss();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule